// File: doc/BRIEF.md
# Multi-Channel 16-bit Overflow Timer

This block is a memory-mapped timer with three independent 16-bit up-counters, set by the `NUM_CH` parameter. Two registers are shared by all channels. The run register holds one run bit per channel. The status register holds an overflow flag and an overflow interrupt enable for each channel. Each channel also has its own control byte, which selects a clock divider, and its own counter, which software can read and load.

The register port addresses bytes. An access moves either one byte or a big-endian halfword. In a halfword access the lower (even) address carries bits 15:8. A counter that passes 0xFFFF returns to 0x0000 and raises its channel's flag. A flag stays set until software writes a 0 to its bit. The channel's interrupt line is high whenever the flag and the matching enable bit are both 1.

Address map (5-bit byte address). The run register is at byte 0 and the status register is at byte 6. Channel k occupies the bytes from 8·(k+1): the control byte is at offset 0, the counter high byte is at offset 2 and the counter low byte is at offset 3. Every other byte reads as 0.

Top module: `tmr16_unit`

## Requirements
- R1: After a synchronous reset, every register reads 0 and every `irq` bit is 0.
- R2: Run-register bit n (byte 0) makes channel n count when 1 and freezes it when 0. Writes do not affect other channels. Bits NUM_CH and above read 0.
- R3: Control-byte bits 2:0 set the divider. A value of 0 advances the counter every cycle, 1 every 2 cycles, 2 every 4 cycles, and 3 to 7 every 8 cycles. The first advance comes after one full divider period, counted from the first clock edge at which the run bit is 1. The whole control byte reads back.
- R4: The divider phase returns to zero whenever the channel is stopped. A stop therefore discards any partial period.
- R5: When a counter advances from 0xFFFF it becomes 0x0000, and bit n of the status register (byte 6) becomes 1.
- R6: Writing a 1 to a flag bit leaves the flag unchanged. Writing a 0 clears it. Other flags are unaffected. Flags cannot be set by a write.
- R7: If an overflow and a software clear of the same flag fall in the same cycle, the flag ends set.
- R8: `irq[n]` is 1 exactly when flag n and enable bit n+4 of the status register are both 1. Bits 3 and 7 of the status register read 0.
- R9: The counter can be loaded with one halfword write at offset 2, or with byte writes to offset 2 (high) and offset 3 (low). Counting resumes from the loaded value.
- R10: Read data is registered and appears one cycle after `bus_rd`. A halfword read returns the even-address byte in bits 15:8. A byte read returns the byte in bits 7:0 with bits 15:8 set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_half | input | 1 | 1 = halfword access (bit 0 of the address ignored), 0 = byte access |
| bus_wdata | input | 16 | Write data (a byte write uses bits 7:0) |
| bus_rdata | output | 16 | Registered read data |
| irq | output | NUM_CH | Per-channel overflow interrupt |

## Verification
Two events can land on the same flag in one cycle: a counter wrapping and a software write that clears the flag. The bench provokes this by parking a counter at 0xFFFF on the fastest divider with its flag already set. It then writes the run bit and, on the very next edge, the clearing status write, so the wrap and the clear meet on the same edge. The flag and the interrupt must both remain 1 afterwards. A later clear with no wrap must then drop both, which shows that the clear path itself works.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int OFS_RUN    = 0;
  localparam int OFS_STAT   = 6;
  localparam int CH_STRIDE  = 8;
  localparam int OFS_CTRL   = 0;
  localparam int OFS_CNT_HI = 2;
  localparam int OFS_CNT_LO = 3;
  localparam int SEL_W      = 3;
endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic [tmr16_pkg::SEL_W-1:0] sel,
  output logic                     tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (int'(sel) > i) mask[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  assign tick = run && ((phase_q & mask) == mask);

  // R4
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase_q == '0));
endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel #(
  parameter int PRE_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run,
  input  logic                        ctrl_we,
  input  logic [tmr16_pkg::BYTE_W-1:0] ctrl_wd,
  input  logic                        hi_we,
  input  logic                        lo_we,
  input  logic [tmr16_pkg::BYTE_W-1:0] hi_wd,
  input  logic [tmr16_pkg::BYTE_W-1:0] lo_wd,
  output logic [tmr16_pkg::BYTE_W-1:0] ctrl_q,
  output logic [tmr16_pkg::CNT_W-1:0]  cnt_q,
  output logic                        ovf_o
);
  import tmr16_pkg::*;
  localparam int HALF = CNT_W / 2;

  logic             tick;
  logic             load;
  logic [CNT_W-1:0] cnt_d;

  tmr16_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .sel (ctrl_q[SEL_W-1:0]),
    .tick(tick)
  );

  assign load = hi_we || lo_we;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      if (hi_we) cnt_d[CNT_W-1:HALF] = hi_wd;
      if (lo_we) cnt_d[HALF-1:0]     = lo_wd;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign ovf_o = tick && !load && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wd;
      cnt_q <= cnt_d;
    end
  end

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> (cnt_q == '0));
  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr16_common.sv
module tmr16_common #(
  parameter int NUM_CH = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run_we,
  input  logic [NUM_CH-1:0]           run_wd,
  input  logic                        stat_we,
  input  logic [NUM_CH-1:0]           flag_wd,
  input  logic [NUM_CH-1:0]           ie_wd,
  input  logic [NUM_CH-1:0]           ovf_in,
  output logic [NUM_CH-1:0]           run_o,
  output logic [tmr16_pkg::BYTE_W-1:0] run_rd,
  output logic [tmr16_pkg::BYTE_W-1:0] stat_rd,
  output logic [NUM_CH-1:0]           irq_o
);
  localparam int IE_POS = 4;

  logic [NUM_CH-1:0] flag_q, flag_d;
  logic [NUM_CH-1:0] ie_q, ie_d;

  always_comb begin
    for (int n = 0; n < NUM_CH; n++)
      flag_d[n] = ovf_in[n] | (flag_q[n] & ~(stat_we & ~flag_wd[n]));
    ie_d = stat_we ? ie_wd : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o  <= '0;
      flag_q <= '0;
      ie_q   <= '0;
      irq_o  <= '0;
    end else begin
      if (run_we) run_o <= run_wd;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_o  <= flag_d & ie_d;
    end
  end

  always_comb begin
    run_rd  = '0;
    stat_rd = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      run_rd[n]           = run_o[n];
      stat_rd[n]          = flag_q[n];
      stat_rd[n + IE_POS] = ie_q[n];
    end
  end

  // R7
  ovf_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_in != '0) |=> ((flag_q & $past(ovf_in)) == $past(ovf_in)));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_we |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (flag_q & ie_q)));
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_half,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  import tmr16_pkg::*;
  localparam int IE_POS = 4;

  initial begin
    assert (NUM_CH <= IE_POS && (NUM_CH + 1) * CH_STRIDE <= (1 << ADDR_W))
      else $error("tmr16_unit: channel count does not fit the map");
  end

  logic [BYTE_W-1:0] ch_ctrl [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
  logic [NUM_CH-1:0] ch_ovf;
  logic [NUM_CH-1:0] run_v;
  logic [BYTE_W-1:0] run_rd, stat_rd;
  logic [ADDR_W-1:0] a_even, a_odd;

  assign a_even = {bus_addr[ADDR_W-1:1], 1'b0};
  assign a_odd  = {bus_addr[ADDR_W-1:1], 1'b1};

  function automatic logic hit(input logic [ADDR_W-1:0] b);
    return bus_wr && (bus_half ? (b[ADDR_W-1:1] == bus_addr[ADDR_W-1:1])
                               : (b == bus_addr));
  endfunction

  function automatic logic [BYTE_W-1:0] lane(input logic [ADDR_W-1:0] b);
    return (bus_half && !b[0]) ? bus_wdata[15:8] : bus_wdata[7:0];
  endfunction

  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(OFS_RUN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic [BYTE_W-1:0] stat_lane;
  assign stat_lane = lane(A_STAT);

  tmr16_common #(.NUM_CH(NUM_CH)) u_common (
    .clk    (clk),
    .rst    (rst),
    .run_we (hit(A_RUN)),
    .run_wd (lane(A_RUN)),
    .stat_we(hit(A_STAT)),
    .flag_wd(stat_lane[NUM_CH-1:0]),
    .ie_wd  (stat_lane[IE_POS+NUM_CH-1:IE_POS]),
    .ovf_in (ch_ovf),
    .run_o  (run_v),
    .run_rd (run_rd),
    .stat_rd(stat_rd),
    .irq_o  (irq)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'((k + 1) * CH_STRIDE + OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'((k + 1) * CH_STRIDE + OFS_CNT_HI);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'((k + 1) * CH_STRIDE + OFS_CNT_LO);

    tmr16_channel #(.PRE_W(PRE_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run_v[k]),
      .ctrl_we(hit(A_CTRL)),
      .ctrl_wd(lane(A_CTRL)),
      .hi_we  (hit(A_HI)),
      .lo_we  (hit(A_LO)),
      .hi_wd  (lane(A_HI)),
      .lo_wd  (lane(A_LO)),
      .ctrl_q (ch_ctrl[k]),
      .cnt_q  (ch_cnt[k]),
      .ovf_o  (ch_ovf[k])
    );
  end

  function automatic logic [BYTE_W-1:0] rd_byte(input logic [ADDR_W-1:0] a);
    logic [BYTE_W-1:0] v;
    v = '0;
    if (a == A_RUN)  v = run_rd;
    if (a == A_STAT) v = stat_rd;
    for (int k = 0; k < NUM_CH; k++) begin
      if (a == ADDR_W'((k + 1) * CH_STRIDE + OFS_CTRL))   v = ch_ctrl[k];
      if (a == ADDR_W'((k + 1) * CH_STRIDE + OFS_CNT_HI)) v = ch_cnt[k][CNT_W-1:BYTE_W];
      if (a == ADDR_W'((k + 1) * CH_STRIDE + OFS_CNT_LO)) v = ch_cnt[k][BYTE_W-1:0];
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= bus_half ? {rd_byte(a_even), rd_byte(a_odd)}
                                            : {8'h00, rd_byte(bus_addr)};
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R10
  byte_read_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_half) |=> (bus_rdata[15:8] == 8'h00));
endmodule

// File: tb/tmr16_unit_tb.sv
module tmr16_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_half = 1'b0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] cnt_model [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_unit #(.NUM_CH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_half(bus_half), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at one
  task automatic wr(input int a, input logic [15:0] d, input bit half);
    bus_addr = AW'(a); bus_wdata = d; bus_half = half; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input bit half, output logic [15:0] d);
    bus_addr = AW'(a); bus_half = half; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int cbase(input int ch);
    return 8 * (ch + 1);
  endfunction

  function automatic int div_of(input int p);
    return (p == 0) ? 1 : (p == 1) ? 2 : (p == 2) ? 4 : 8;
  endfunction

  // run channel mask for m+1 clock edges
  task automatic run_edges(input int mask, input int m);
    wr(0, 16'(mask), 1'b0);
    repeat (m) @(negedge clk);
    wr(0, 16'h0000, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    foreach (cnt_model[i]) cnt_model[i] = 16'h0000;
    rd(0, 1'b1, d);  check("R1 run/byte1", d, 16'h0000);
    rd(6, 1'b1, d);  check("R1 status", d, 16'h0000);
    for (int ch = 0; ch < NCH; ch++) begin
      rd(cbase(ch), 1'b1, d);     check("R1 ctrl", d, 16'h0000);
      rd(cbase(ch) + 2, 1'b1, d); check("R1 counter", d, 16'h0000);
    end
    check("R1 irq", 16'(irq), 16'h0000);

    // R3 divider sweep, R2 other channel frozen
    for (int ch = 0; ch < NCH; ch++) begin
      for (int p = 0; p < 8; p++) begin
        for (int k = 0; k < 2; k++) begin
          automatic int m = (k == 0) ? 20 : 37;
          automatic int oth = (ch + 1) % NCH;
          wr(cbase(ch) + 2, 16'h0000, 1'b1);
          wr(cbase(ch), 16'(p), 1'b0);
          run_edges(1 << ch, m);
          cnt_model[ch] = 16'((m + 1) / div_of(p));
          rd(cbase(ch) + 2, 1'b1, d);
          check($sformatf("R3 ch%0d sel%0d m%0d", ch, p, m), d, cnt_model[ch]);
          rd(cbase(oth) + 2, 1'b1, d);
          check("R2 idle channel frozen", d, cnt_model[oth]);
        end
      end
    end

    // R4 partial period discarded on stop
    wr(cbase(0) + 2, 16'h0000, 1'b1);
    wr(cbase(0), 16'h0003, 1'b0);
    run_edges(1, 4);
    run_edges(1, 4);
    rd(cbase(0) + 2, 1'b1, d); check("R4 partial periods dropped", d, 16'h0000);
    run_edges(1, 7);
    rd(cbase(0) + 2, 1'b1, d); check("R4 full period after restart", d, 16'h0001);

    // R2 run register bits above channels read 0
    wr(0, 16'h00FF, 1'b0);
    rd(0, 1'b0, d); check("R2 run readback", d, 16'h0007);
    wr(0, 16'h0000, 1'b0);

    // R5 wrap and flag
    wr(cbase(1), 16'h0000, 1'b0);
    wr(cbase(1) + 2, 16'hFFFE, 1'b1);
    run_edges(2, 1);
    rd(cbase(1) + 2, 1'b1, d); check("R5 wrap to zero", d, 16'h0000);
    rd(6, 1'b0, d); check("R5 flag set", d, 16'h0002);
    check("R8 no irq without enable", 16'(irq), 16'h0000);

    // R8 enable, R6 write-1 keeps flag
    wr(6, 16'h0022, 1'b0);
    check("R8 irq with enable", 16'(irq), 16'h0002);
    rd(6, 1'b0, d); check("R6 write 1 keeps flag", d, 16'h0022);
    wr(6, 16'h0020, 1'b0);
    check("R8 irq drops on clear", 16'(irq), 16'h0000);
    rd(6, 1'b0, d); check("R6 write 0 clears", d, 16'h0020);

    // R6 per-bit clear with two flags
    for (int ch = 0; ch < NCH; ch += 2) begin
      wr(cbase(ch), 16'h0000, 1'b0);
      wr(cbase(ch) + 2, 16'hFFFF, 1'b1);
    end
    run_edges(5, 0);
    rd(6, 1'b0, d); check("R5 two flags", d, 16'h0025);
    wr(6, 16'h0024, 1'b0);
    rd(6, 1'b0, d); check("R6 clear bit0 only", d, 16'h0024);
    wr(6, 16'h00FB, 1'b0);
    rd(6, 1'b1, d); check("R8 reserved bits zero / R6 flag not settable", d, 16'h7000);
    check("R8 irq all enabled, no flags", 16'(irq), 16'h0000);

    // R7 wrap and clear on the same edge (ch2 flag set first)
    wr(6, 16'h0040, 1'b0);
    wr(cbase(2) + 2, 16'hFFFF, 1'b1);
    run_edges(4, 0);
    rd(6, 1'b0, d); check("R7 precondition flag", d, 16'h0044);
    wr(cbase(2) + 2, 16'hFFFF, 1'b1);
    wr(0, 16'h0004, 1'b0);   // run on this edge
    wr(6, 16'h0040, 1'b0);   // wrap and clear on this edge
    wr(0, 16'h0000, 1'b0);
    rd(6, 1'b0, d); check("R7 overflow beats clear", d, 16'h0044);
    check("R7 irq stays", 16'(irq), 16'h0004);
    wr(6, 16'h0040, 1'b0);
    rd(6, 1'b0, d); check("R7 plain clear works", d, 16'h0040);
    check("R8 irq low after clear", 16'(irq), 16'h0000);

    // R9 byte loads and resume, R10 lane mapping
    wr(cbase(0) + 2, 16'h0012, 1'b0);
    wr(cbase(0) + 3, 16'h0034, 1'b0);
    rd(cbase(0) + 2, 1'b1, d); check("R9/R10 halfword read", d, 16'h1234);
    rd(cbase(0) + 2, 1'b0, d); check("R10 byte read high", d, 16'h0012);
    rd(cbase(0) + 3, 1'b0, d); check("R10 byte read low", d, 16'h0034);
    wr(cbase(0), 16'h0000, 1'b0);
    run_edges(1, 3);
    rd(cbase(0) + 2, 1'b1, d); check("R9 resume from load", d, 16'h1238);

    // R3 control readback
    wr(cbase(1), 16'h00A5, 1'b0);
    rd(cbase(1), 1'b0, d); check("R3 control readback", d, 16'h00A5);
    rd(cbase(1), 1'b1, d); check("R10 halfword ctrl lane", d, 16'hA500);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule